// File: doc/BRIEF.md
# Sample clock source selector

This block picks the clock that drives an acquisition memory. There are three candidate clock lines. The first is a display-readout clock. The second is an internal store clock from a timebase. The third is an external sample clock. The choice depends on two levels. One is a store-mode flag from the trigger logic. The other is an active-low external-select level from the sample-interval setting. Each candidate passes through its own gate. The single output clock is the OR of the three gated paths. The external clock is inverted on its way through its gate.

Outside store mode only the display clock reaches the output. In store mode the internal store clock is used. If external select is also asserted, the external clock is used instead. In every case exactly one path is enabled. The parameter `GLITCH_SAFE` selects one of two variants:

- The direct variant decodes the enables combinationally from the mode inputs.
- The glitch-safe variant works as follows:
  - It synchronises the mode inputs to a system clock.
  - It keeps the path enables in a register.
  - It removes the old path only while the output is LO.
  - It adds the new path only while that path's own level is LO.

As a result, a change of source never produces a shortened HI pulse.

Top module: `sclk_source_sel`

## Requirements
- R1: With the store-mode input LO, the output equals the display clock (path 0), whatever the other two clock lines do.
- R2: With the store-mode input HI and the external-select input HI, the output equals the internal store clock (path 1).
- R3: With the store-mode input HI and the external-select input LO, the output equals the inverse of the external clock (path 2). The external path never passes while store mode is LO.
- R4: At most one path is enabled at any time. A clock line whose path is not selected has no effect on the output.
- R5: While reset is asserted, the glitch-safe variant holds its output LO and has no path enabled.
- R6: In the glitch-safe variant, an enabled path is removed only in a cycle where the output is LO. Every output HI pulse is therefore at least as long as the source's own HI phase.
- R7: In the glitch-safe variant, a newly chosen path is enabled only in a cycle where its level after inversion is LO. After reset, the display path stays off until the display clock has been seen LO.
- R8: Once the mode inputs are stable, the glitch-safe output follows the selected source within 60 system-clock cycles, provided every source toggles at least every 5 cycles. After that, the enables stay unchanged.
- R9: The direct variant (`GLITCH_SAFE` = 0) applies R1 to R3 combinationally. Its output follows input changes in the same time step, without a system-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the select synchroniser and enable register |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_clk_i | input | 1 | Display-readout clock (path 0) |
| store_clk_i | input | 1 | Internal store clock from the timebase (path 1) |
| ext_clk_i | input | 1 | External sample clock, inverted when passed (path 2) |
| store_mode_i | input | 1 | Store mode from trigger logic, HI = store |
| ext_sel_n_i | input | 1 | External sample select, LO = use external clock |
| smp_clk_o | output | 1 | Selected sample clock |

## Verification
A wrong enable register would show up at the output in one of two ways. A stray enable would OR in a foreign clock line. A missing enable would hold the output at a constant level while its selected source toggles. Either fault appears in the first static level pattern applied after the source change has settled. An early drop or early load of an enable would cut an output HI pulse short. The pulse-width monitor flags that at the end of the first shortened pulse. A wrong decode in the direct variant is visible in the same time step as the input change.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int unsigned NUM_PATHS  = 3;
    localparam int unsigned PATH_DISP  = 0;
    localparam int unsigned PATH_STORE = 1;
    localparam int unsigned PATH_EXT   = 2;

    typedef logic [NUM_PATHS-1:0] path_vec_t;

    // paths whose source is inverted on the way through the gate
    localparam path_vec_t INV_MASK = path_vec_t'(1) << PATH_EXT;

    typedef enum logic {
        SW_OFF = 1'b0,
        SW_ON  = 1'b1
    } sw_state_e;

    typedef struct packed {
        sw_state_e st;
        path_vec_t en;
    } sw_reg_t;

    typedef struct packed {
        logic store;
        logic ext_sel_n;
    } sel_t;

    localparam sel_t SEL_RST = '{store: 1'b0, ext_sel_n: 1'b1};

endpackage

// File: rtl/sclk_path_decode.sv
module sclk_path_decode
    import sclk_pkg::*;
(
    input  sel_t      sel,
    output path_vec_t en
);

    always_comb begin
        en = '0;
        if (!sel.store) begin
            en[PATH_DISP] = 1'b1;
        end else if (sel.ext_sel_n) begin
            en[PATH_STORE] = 1'b1;
        end else begin
            en[PATH_EXT] = 1'b1;
        end
    end

endmodule

// File: rtl/sclk_level.sv
module sclk_level
    import sclk_pkg::*;
#(
    parameter path_vec_t INV = INV_MASK
) (
    input  path_vec_t src,
    output path_vec_t lvl
);

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        if (INV[g]) begin : g_inv
            assign lvl[g] = ~src[g];
        end else begin : g_pass
            assign lvl[g] = src[g];
        end
    end

endmodule

// File: rtl/sclk_gate_or.sv
module sclk_gate_or
    import sclk_pkg::*;
(
    input  path_vec_t lvl,
    input  path_vec_t en,
    output logic      out
);

    path_vec_t gated;

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_gate
        assign gated[g] = lvl[g] & en[g];
    end

    assign out = |gated;

endmodule

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int unsigned       WIDTH   = 2,
    parameter int unsigned       DEPTH   = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_d [DEPTH];
    logic [WIDTH-1:0] stg_q [DEPTH];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[DEPTH-1];

endmodule

// File: rtl/sclk_switch_ctrl.sv
module sclk_switch_ctrl
    import sclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  path_vec_t req,
    input  path_vec_t lvl,
    input  logic      out_hi,
    output path_vec_t en_q
);

    sw_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SW_OFF: begin
                // attach the new path only while its level is LO
                if ((req != '0) && ((req & lvl) == '0)) begin
                    r_d.st = SW_ON;
                    r_d.en = req;
                end
            end
            SW_ON: begin
                // detach the old path only while the output is LO
                if ((req != r_q.en) && !out_hi) begin
                    r_d.st = SW_OFF;
                    r_d.en = '0;
                end
            end
            default: begin
                r_d.st = SW_OFF;
                r_d.en = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SW_OFF, en: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign en_q = r_q.en;

endmodule

// File: rtl/sclk_source_sel.sv
module sclk_source_sel
    import sclk_pkg::*;
#(
    parameter bit          GLITCH_SAFE = 1'b1,
    parameter int unsigned SYNC_DEPTH  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disp_clk_i,
    input  logic store_clk_i,
    input  logic ext_clk_i,
    input  logic store_mode_i,
    input  logic ext_sel_n_i,
    output logic smp_clk_o
);

    localparam int unsigned SEL_W = $bits(sel_t);

    path_vec_t src;
    path_vec_t lvl;
    path_vec_t req;
    path_vec_t en_q;
    sel_t      sel_raw;
    sel_t      sel_sync;
    logic      out_reg;

    assign src[PATH_DISP]  = disp_clk_i;
    assign src[PATH_STORE] = store_clk_i;
    assign src[PATH_EXT]   = ext_clk_i;

    assign sel_raw = '{store: store_mode_i, ext_sel_n: ext_sel_n_i};

    sclk_level #(.INV(INV_MASK)) u_level (
        .src (src),
        .lvl (lvl)
    );

    sclk_sync #(
        .WIDTH   (SEL_W),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (SEL_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sel_raw),
        .q     (sel_sync)
    );

    sclk_path_decode u_req (
        .sel (sel_sync),
        .en  (req)
    );

    sclk_switch_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .lvl    (lvl),
        .out_hi (out_reg),
        .en_q   (en_q)
    );

    sclk_gate_or u_gate_reg (
        .lvl (lvl),
        .en  (en_q),
        .out (out_reg)
    );

    if (GLITCH_SAFE) begin : g_safe
        assign smp_clk_o = out_reg;
    end else begin : g_direct
        path_vec_t en_raw;
        logic      out_raw;

        sclk_path_decode u_dec_raw (
            .sel (sel_raw),
            .en  (en_raw)
        );

        sclk_gate_or u_gate_raw (
            .lvl (lvl),
            .en  (en_raw),
            .out (out_raw)
        );

        assign smp_clk_o = out_raw;
    end

endmodule

// File: rtl/sclk_source_sel_chk.sv
module sclk_source_sel_chk
    import sclk_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input path_vec_t en_q,
    input path_vec_t lvl,
    input path_vec_t req,
    input logic      out_reg
);

    AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_q)) else $error("enable not one-hot"); // R4

    AST_HOLD_WHILE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q != '0) && out_reg) |=> (en_q == $past(en_q))) else $error("path dropped while HI"); // R6

    AST_LOAD_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> ((en_q & $past(lvl)) == '0)) else $error("path added while HI"); // R7

    AST_STAY_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q == req) && (en_q != '0)) |=> $stable(en_q)) else $error("enable moved when matched"); // R8

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RST_QUIET: assert (!out_reg && (en_q == '0)) else $error("active in reset"); // R5
        end
    end

endmodule

bind sclk_source_sel sclk_source_sel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_q    (en_q),
    .lvl     (lvl),
    .req     (req),
    .out_reg (out_reg)
);

// File: tb/sclk_source_sel_tb_top.sv
module sclk_source_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [2:0] stat = 3'b000;
    logic [2:0] gen = 3'b000;
    int         gcnt [3];
    logic       store_m = 1'b0;
    logic       ext_n = 1'b1;
    logic       out_r;
    logic       out_c;
    wire  [2:0] src = run ? gen : stat;

    int total = 0;
    int bad = 0;
    int mon_total = 0;
    int mon_bad = 0;
    int hi_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sclk_source_sel dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .disp_clk_i   (src[0]),
        .store_clk_i  (src[1]),
        .ext_clk_i    (src[2]),
        .store_mode_i (store_m),
        .ext_sel_n_i  (ext_n),
        .smp_clk_o    (out_r)
    );

    sclk_source_sel #(.GLITCH_SAFE(1'b0)) dut_comb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .disp_clk_i   (src[0]),
        .store_clk_i  (src[1]),
        .ext_clk_i    (src[2]),
        .store_mode_i (store_m),
        .ext_sel_n_i  (ext_n),
        .smp_clk_o    (out_c)
    );

    // free-running sources, half periods 3, 4 and 5 system cycles
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!run) begin
                gen[i]  = 1'b0;
                gcnt[i] = 0;
            end else if (gcnt[i] == i + 2) begin
                gen[i]  = ~gen[i];
                gcnt[i] = 0;
            end else begin
                gcnt[i] = gcnt[i] + 1;
            end
        end
    end

    // HI pulse width monitor for the glitch-safe output (R6, R7)
    always begin
        @(posedge clk);
        #2;
        if (run && rst_n) begin
            if (out_r) begin
                hi_cnt = hi_cnt + 1;
            end else if (hi_cnt > 0) begin
                mon_total = mon_total + 1;
                if (hi_cnt < 3) begin
                    mon_bad = mon_bad + 1;
                    $display("FAIL R6 R7 hi pulse width act=%0d exp>=3", hi_cnt);
                end
                hi_cnt = 0;
            end
        end else begin
            hi_cnt = 0;
        end
    end

    function automatic logic exp_f(logic st, logic en_n, logic [2:0] lv);
        if (!st)  return lv[0];
        if (en_n) return lv[1];
        return ~lv[2];
    endfunction

    function automatic string sel_tag(logic st, logic en_n);
        if (!st)  return "R1";
        if (en_n) return "R2";
        return "R3";
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    initial begin
        // reset with all lines HI (R5)
        rst_n = 1'b0; stat = 3'b111; store_m = 1'b0; ext_n = 1'b1;
        repeat (4) @(posedge clk);
        #2 chk("R5 out in reset", out_r, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #2 chk("R7 display held off while HI", out_r, 1'b0);
        @(negedge clk) stat[0] = 1'b0;
        @(posedge clk);
        #2 chk("R7 display loads while LO", out_r, 1'b0);
        @(negedge clk) stat[0] = 1'b1;
        @(posedge clk);
        #2 chk("R1 display passes", out_r, 1'b1);
        @(negedge clk) stat = 3'b110;
        @(posedge clk);
        #2 chk("R4 other lines ignored", out_r, 1'b0);

        // direct variant, every input pattern (R9)
        for (int v = 0; v < 32; v++) begin
            @(posedge clk);
            #1;
            store_m = v[4]; ext_n = v[3]; stat = v[2:0];
            #1 chk($sformatf("R9 %s R4 direct v=%0d", sel_tag(v[4], v[3]), v),
                   out_c, exp_f(v[4], v[3], v[2:0]));
        end

        // glitch-safe variant: every ordered pair of selections
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                store_m = a[1]; ext_n = a[0]; run = 1'b1;
                repeat (60) @(negedge clk);
                store_m = b[1]; ext_n = b[0];
                repeat (60) @(negedge clk);
                run = 1'b0;
                for (int lv = 0; lv < 8; lv++) begin
                    if (lv != 0) @(negedge clk);
                    stat = lv[2:0];
                    @(posedge clk);
                    #2;
                    chk($sformatf("%s R4 R8 from=%0d to=%0d lv=%0d",
                                  sel_tag(b[1], b[0]), a, b, lv),
                        out_r, exp_f(b[1], b[0], lv[2:0]));
                    chk($sformatf("R9 direct to=%0d lv=%0d", b, lv),
                        out_c, exp_f(b[1], b[0], lv[2:0]));
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            $display("FAIL watchdog act=timeout exp=finished");
            $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
            $finish;
        end
    end

endmodule